// File: doc/BRIEF.md
# PLL Output Rate Recalculator

This block works out the output frequency of a phase-locked loop from its programmed settings. It takes the reference clock frequency in hertz, the feedback divider word and a 3-bit post-divider code. It returns the output frequency in hertz. The feedback word is fixed-point. Its top seven bits are the integer part and any bits below them are fractional.

The datapath has three registered stages. The first forms the full-width product of reference and feedback word, which is the oscillator frequency scaled by the fractional weight. The second drops the fractional bits and rounds up if any of them were set. The third divides by the power-of-two post-divider, also rounding up. A request is presented with a one-cycle start pulse. A new request may be issued on every cycle. The result appears with a valid pulse a fixed number of cycles later.

Top module: `pll_rate_calc`

## Requirements
- R1: The fractional bit count is WORD_W minus 7 when WORD_W exceeds 7, and zero otherwise; with zero fractional bits the product is passed on without any rounding.
- R2: The product of reference frequency and feedback word is formed at full width with no truncation, including both operands at their all-ones maximum (32 bits each gives a 64-bit product).
- R3: After the product is shifted right by the fractional count, the result is incremented by one if any of the discarded low bits were nonzero; an exact multiple is not incremented.
- R4: The post-divider equals 1 shifted left by the 3-bit code, so codes 0 through 7 select divide by 1, 2, 4, ... 128.
- R5: The output frequency is the ceiling of the rounded value divided by the post-divider.
- R6: valid_o is high for exactly one cycle, three rising clock edges after the edge that samples start_i high, and rate_hz_o carries the matching result in that cycle; back-to-back starts give back-to-back results.
- R7: A cycle with start_i low produces no valid pulse three edges later, and rate_hz_o keeps the last produced result whenever valid_o is low.
- R8: While rst_n is low, valid_o is 0 and rate_hz_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; inputs sampled when high |
| ref_hz_i | input | REF_W | Reference frequency in hertz |
| fb_word_i | input | WORD_W | Feedback divider word, 7 integer bits then fraction |
| pdiv_code_i | input | 3 | Post-divider code (divide by 2^code) |
| valid_o | output | 1 | Result strobe |
| rate_hz_o | output | 64 | Output frequency in hertz, held between results |

## Verification
Each result is due on the third rising edge after the edge that samples start_i. Only the valid pulse and the new rate value change there. The bench drives inputs on the falling edge and samples just before it drives. It keeps a three-deep history of the stimuli it applied. It compares valid_o and rate_hz_o with the entry that is three falling edges old. For idle cycles, the expected rate is the last result. A fractional configuration and a configuration with no fraction run side by side on the same cycles.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
    localparam int INT_BITS = 7;
    localparam int PROD_W   = 64;
    localparam int CODE_W   = 3;

    typedef logic [PROD_W-1:0] prod_t;
    typedef logic [CODE_W-1:0] code_t;

    function automatic int frac_count(input int word_w);
        return (word_w > INT_BITS) ? (word_w - INT_BITS) : 0;
    endfunction
endpackage

// File: rtl/prc_mul_stage.sv
module prc_mul_stage
    import pll_rate_pkg::*;
#(
    parameter int REF_W  = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [REF_W-1:0]  ref_i,
    input  logic [WORD_W-1:0] word_i,
    input  code_t             code_i,
    output logic              vld_o,
    output prod_t             prod_o,
    output code_t             code_o
);
    typedef struct packed {
        logic  vld;
        prod_t prod;
        code_t code;
    } mul_st_t;

    mul_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.prod = PROD_W'(ref_i) * PROD_W'(word_i);
            st_d.code = code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign prod_o = st_q.prod;
    assign code_o = st_q.code;

    // R2: unit word passes the reference through untruncated
    assert_unit_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && word_i == WORD_W'(1)) |=> (prod_o == PROD_W'($past(ref_i))));

    // R2: zero reference yields zero product
    assert_zero_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && ref_i == '0) |=> (prod_o == '0));
endmodule

// File: rtl/prc_frac_round.sv
module prc_frac_round
    import pll_rate_pkg::*;
#(
    parameter int FRAC_W = 25
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vld_i,
    input  prod_t prod_i,
    input  code_t code_i,
    output logic  vld_o,
    output prod_t val_o,
    output code_t code_o
);
    typedef struct packed {
        logic  vld;
        prod_t val;
        code_t code;
    } rnd_st_t;

    rnd_st_t st_d, st_q;
    prod_t   rounded;

    generate
        if (FRAC_W == 0) begin : g_integer
            assign rounded = prod_i;
        end else begin : g_fraction
            logic sticky;
            assign sticky  = |prod_i[FRAC_W-1:0];
            assign rounded = (prod_i >> FRAC_W) + PROD_W'(sticky);

            // R3: the scaled value never falls below the exact quotient
            assert_round_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
                vld_i |=> (({1'b0, val_o} << FRAC_W) >= {1'b0, $past(prod_i)}));

            // R3: round-up adds at most one
            assert_round_ceil_R3: assert property (@(posedge clk) disable iff (!rst_n)
                vld_i |=> (val_o <= ($past(prod_i) >> FRAC_W) + 1));
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.val  = rounded;
            st_d.code = code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign val_o  = st_q.val;
    assign code_o = st_q.code;
endmodule

// File: rtl/prc_post_div.sv
module prc_post_div
    import pll_rate_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vld_i,
    input  prod_t val_i,
    input  code_t code_i,
    output logic  vld_o,
    output prod_t rate_o
);
    typedef struct packed {
        logic  vld;
        prod_t rate;
    } div_st_t;

    div_st_t           st_d, st_q;
    logic [PROD_W:0]   bias;
    logic [PROD_W:0]   sum;

    // divisor minus one, then add-and-shift for the ceiling
    assign bias = ({{PROD_W{1'b0}}, 1'b1} << code_i) - 1'b1;
    assign sum  = {1'b0, val_i} + bias;

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.rate = PROD_W'(sum >> code_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign rate_o = st_q.rate;

    // R5: result times divisor covers the dividend
    assert_ceil_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (({1'b0, rate_o} << $past(code_i)) >= {1'b0, $past(val_i)}));

    // R5: result exceeds the floor quotient by at most one
    assert_ceil_tight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (rate_o <= ($past(val_i) >> $past(code_i)) + 1));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_rate_pkg::*;
#(
    parameter int REF_W  = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REF_W-1:0]  ref_hz_i,
    input  logic [WORD_W-1:0] fb_word_i,
    input  logic [2:0]        pdiv_code_i,
    output logic              valid_o,
    output logic [63:0]       rate_hz_o
);
    localparam int FRAC_W = frac_count(WORD_W);

    generate
        if (REF_W + WORD_W > PROD_W) begin : g_bad_width
            $error("reference and word widths exceed the product width");
        end
    endgenerate

    logic  m_vld, r_vld;
    prod_t m_prod, r_val;
    code_t m_code, r_code;

    prc_mul_stage #(.REF_W(REF_W), .WORD_W(WORD_W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (start_i),
        .ref_i  (ref_hz_i),
        .word_i (fb_word_i),
        .code_i (pdiv_code_i),
        .vld_o  (m_vld),
        .prod_o (m_prod),
        .code_o (m_code)
    );

    prc_frac_round #(.FRAC_W(FRAC_W)) u_round (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (m_vld),
        .prod_i (m_prod),
        .code_i (m_code),
        .vld_o  (r_vld),
        .val_o  (r_val),
        .code_o (r_code)
    );

    prc_post_div u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (r_vld),
        .val_i  (r_val),
        .code_i (r_code),
        .vld_o  (valid_o),
        .rate_o (rate_hz_o)
    );

    // R6: a sampled start yields a result three edges later
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ##3 valid_o);

    // R7: no result without a start three edges earlier
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(start_i, 3));

    // R7: output holds between results
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(rate_hz_o));

    // R8: reset clears the outputs
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |-> (!valid_o && rate_hz_o == '0));
endmodule

// File: tb/test_pll_rate_calc.sv
module test_pll_rate_calc;
    localparam int CLK_PERIOD = 10;
    localparam int A_FRAC = 25;  // 32-bit word: 7 integer bits
    localparam int B_FRAC = 0;   // 6-bit word: no fraction (R1)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_a = '0, word_a = '0;
    logic [7:0]  ref_b = '0;
    logic [5:0]  word_b = '0;
    logic [2:0]  code = '0;
    logic        vld_a, vld_b;
    logic [63:0] rate_a, rate_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        h_st [3];
    logic [63:0] h_ea [3];
    logic [63:0] h_eb [3];
    string       h_tag [3];
    logic [63:0] last_a = '0, last_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_rate_calc #(.REF_W(32), .WORD_W(32)) i_pll_rate_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ref_hz_i(ref_a),
        .fb_word_i(word_a), .pdiv_code_i(code), .valid_o(vld_a), .rate_hz_o(rate_a)
    );

    pll_rate_calc #(.REF_W(8), .WORD_W(6)) i_pll_rate_calc_int (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ref_hz_i(ref_b),
        .fb_word_i(word_b), .pdiv_code_i(code), .valid_o(vld_b), .rate_hz_o(rate_b)
    );

    function automatic logic [63:0] model(input logic [63:0] r, input logic [63:0] w,
                                          input int frac, input int c);
        logic [63:0] p, v, pd;
        p = r * w;
        v = p >> frac;
        if (frac > 0 && (p % (64'd1 << frac)) != 0) v = v + 1;
        pd = 64'd1 << c;
        return v / pd + (((v % pd) != 0) ? 64'd1 : 64'd0);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // one cycle: sample results of the stimulus three edges old, then drive
    task automatic step(input logic st, input logic [31:0] ra, input logic [31:0] wa,
                        input logic [7:0] rb, input logic [5:0] wb,
                        input logic [2:0] c, input string tag);
        @(negedge clk);
        if (h_st[2]) begin
            last_a = h_ea[2];
            last_b = h_eb[2];
        end
        check(h_st[2] ? "R6" : "R7", "valid A", 64'(vld_a), 64'(h_st[2]));
        check(h_st[2] ? "R6" : "R7", "valid B", 64'(vld_b), 64'(h_st[2]));
        check(h_st[2] ? h_tag[2] : "R7", "rate A", rate_a, last_a);
        check(h_st[2] ? {h_tag[2], " R1"} : "R7", "rate B", rate_b, last_b);
        start  = st;
        ref_a  = ra;
        word_a = wa;
        ref_b  = rb;
        word_b = wb;
        code   = c;
        for (int k = 2; k > 0; k--) begin
            h_st[k]  = h_st[k-1];
            h_ea[k]  = h_ea[k-1];
            h_eb[k]  = h_eb[k-1];
            h_tag[k] = h_tag[k-1];
        end
        h_st[0]  = st;
        h_ea[0]  = model(64'(ra), 64'(wa), A_FRAC, int'(c));
        h_eb[0]  = model(64'(rb), 64'(wb), B_FRAC, int'(c));
        h_tag[0] = tag;
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            h_st[k] = 1'b0; h_ea[k] = '0; h_eb[k] = '0; h_tag[k] = "R7";
        end
        repeat (3) @(negedge clk);
        // R8: outputs cleared in reset
        check("R8", "valid A in reset", 64'(vld_a), 64'd0);
        check("R8", "rate A in reset", rate_a, 64'd0);
        check("R8", "rate B in reset", rate_b, 64'd0);
        rst_n = 1'b1;

        // R2: both operands at maximum, every divider code (R4)
        for (int c = 0; c < 8; c++)
            step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 6'h3F, 3'(c), "R2 R4");
        // R3: exact multiple of the fraction weight versus one LSB above it
        step(1'b1, 32'd26_000_000, 32'h0200_0000, 8'd128, 6'd2, 3'd0, "R3");
        step(1'b1, 32'd26_000_000, 32'h0200_0001, 8'd129, 6'd3, 3'd0, "R3");
        step(1'b1, 32'd1, 32'h0000_0001, 8'd1, 6'd1, 3'd7, "R3 R5");
        step(1'b1, 32'd0, 32'h1234_5678, 8'd0, 6'd9, 3'd3, "R5");
        // R7: idle cycles with changing inputs produce nothing
        step(1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 8'd77, 6'd33, 3'd5, "R7");
        step(1'b0, 32'h0BAD_0BAD, 32'h7777_7777, 8'd11, 6'd22, 3'd1, "R7");

        // R5 sweep: B covers refs in steps of 4, all words, all codes
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                for (int c = 0; c < 8; c++) begin
                    if (((i + j + c) % 7) == 0)
                        step(1'b0, 32'(i * 977), 32'(j * 31), 8'(i), 6'(j), 3'(c), "R7");
                    step(1'b1, 32'((i * 40503 + 1) * 1237), 32'(j * 32'h0513_2F41 + i),
                         8'(i * 4), 6'(j), 3'(c), "R5");
                end
            end
        end
        repeat (4) step(1'b0, '0, '0, '0, '0, '0, "R7");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule